// File: doc/BRIEF.md
# Two-Stage I2C Clock Phase Generator

This block derives the serial clock timing for an I2C master from its system clock. A first prescale stage divides the system clock by (A+1), where A is a 2-bit divisor. A second stage divides that result by (B+1), where B is a 6-bit divisor. Every output of the second stage is one "scaled tick". Each serial clock period lasts a fixed 22 scaled ticks, so the serial clock frequency is f_clk / (22 × (A+1) × (B+1)). The combined factor N = (A+1)×(B+1) covers 1 to 256.

Within each period, the block emits four one-cycle strobes for the bit engine. The first marks the falling edge of the serial clock. The second marks the point where SDA may change. The third marks the release of the serial clock. The fourth marks the point where SDA is sampled. The block drives the clock line as a release/pull-low control, and it reads the line back. If a slave holds the line low after release, the whole divider freezes until the line reads high.

Divisor values are captured while the block is disabled and again at each period boundary. A write in the middle of a period therefore never distorts the period in progress. When the block is disabled it clears all counters and leaves the line released.

Top module: `i2c_scl_divider`

## Requirements
- R1: While `en_i` is low, and during reset, `scl_o` is 1 (released) and `ev_o` is 0. Every enable therefore starts from cleared counters.
- R2: With `en_i` held high, a scaled tick occurs every N = (`div_a_i`+1)×(`div_b_i`+1) clock cycles. The first falling strobe appears on the N-th rising clock edge after `en_i` is first sampled high.
- R3: Each serial clock period lasts 22·N cycles. `scl_o` is 0 for the first 11·N cycles after a falling strobe and 1 for the next 11·N cycles.
- R4: `ev_o` uses these bits: bit 0 marks the fall, at phase tick 0; bit 1 marks the SDA change, at tick 5; bit 2 marks the release, at tick 11; bit 3 marks the sample, at tick 16. The tick counts are in scaled ticks after the falling strobe.
- R5: Each strobe lasts one cycle, and at most one bit of `ev_o` is set in any cycle.
- R6: A divisor value applied while enabled takes effect only at the next period boundary. The period in progress keeps its old timing, and the next period runs entirely with the new N.
- R7: If `scl_o` is 1 while `scl_i` reads 0, all divider state freezes and no strobes are issued. Counting resumes when `scl_i` reads high, so the release-to-sample interval grows by exactly the number of frozen cycles.
- R8: Both extremes work: N=1 (A=0, B=0) gives a 22-cycle period, and N=256 (A=3, B=63) gives a 5632-cycle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Divider enable; low clears counters and releases the line |
| div_a_i | input | 2 | First-stage divisor A (divide by A+1) |
| div_b_i | input | 6 | Second-stage divisor B (divide by B+1) |
| scl_i | input | 1 | Sensed serial clock line level, synchronous to clk_i |
| scl_o | output | 1 | Serial clock control: 1 = release, 0 = pull low |
| ev_o | output | 4 | Phase strobes: bit0 fall, bit1 SDA change, bit2 release, bit3 sample |

## Verification
The assertions assume three things. First, `scl_i` is already synchronous to `clk_i`. Second, it can read low while `scl_o` is released only because a slave stretches the clock. Third, the divisor inputs may change in any cycle, but only the captured copy is constrained. The stimulus meets these conditions. It derives the line level as `scl_o` ANDed with a bench-controlled hold, and it raises that hold only after the first falling strobe. It changes the divisors at falling clock edges, either while the block is disabled or in the middle of an enabled period. The random cases draw A and B under a fixed seed, and directed cases cover N=1, N=256, a mid-period divisor change and a stretch.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
  localparam int NUM_EV = 4;
  typedef enum int {
    EV_FALL   = 0,
    EV_DRIVE  = 1,
    EV_RISE   = 2,
    EV_SAMPLE = 3
  } scl_ev_e;
  typedef logic [NUM_EV-1:0] scl_ev_t;
endpackage

// File: rtl/i2c_scl_stage.sv
module i2c_scl_stage #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         adv_i,
  input  logic [W-1:0] lim_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;
  logic         hit;

  assign hit    = (cnt_q == lim_i);
  assign done_o = adv_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (adv_i) cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim_i);
endmodule

// File: rtl/i2c_scl_phase.sv
module i2c_scl_phase
  import i2c_scl_pkg::*;
#(
  parameter int PHASES = 22
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    en_i,
  input  logic    tick_i,
  input  logic    scl_i,
  output logic    scl_o,
  output scl_ev_t ev_o,
  output logic    period_end_o,
  output logic    stretch_o
);
  localparam int PH_W = $clog2(PHASES);
  localparam int LAST = PHASES - 1;
  localparam int HALF = PHASES / 2;
  localparam int QTR  = PHASES / 4;

  logic [PH_W-1:0] ph_q, ph_nxt;
  logic            scl_q;
  scl_ev_t         ev_q, ev_nxt;

  assign ph_nxt       = (ph_q == PH_W'(LAST)) ? '0 : ph_q + 1'b1;
  assign period_end_o = tick_i & (ph_q == PH_W'(LAST));
  assign stretch_o    = en_i & scl_q & ~scl_i;

  always_comb begin
    ev_nxt            = '0;
    ev_nxt[EV_FALL]   = (ph_nxt == '0);
    ev_nxt[EV_DRIVE]  = (ph_nxt == PH_W'(QTR));
    ev_nxt[EV_RISE]   = (ph_nxt == PH_W'(HALF));
    ev_nxt[EV_SAMPLE] = (ph_nxt == PH_W'(HALF + QTR));
  end

  // idle parks on the last high tick so the first tick wraps into a fall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_W'(LAST);
      scl_q <= 1'b1;
      ev_q  <= '0;
    end else if (!en_i) begin
      ph_q  <= PH_W'(LAST);
      scl_q <= 1'b1;
      ev_q  <= '0;
    end else begin
      ev_q <= '0;
      if (tick_i) begin
        ph_q  <= ph_nxt;
        scl_q <= (ph_nxt >= PH_W'(HALF));
        ev_q  <= ev_nxt;
      end
    end
  end

  assign scl_o = scl_q;
  assign ev_o  = ev_q;

  // R1
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (scl_q && ev_q == '0));
  // R5
  ev_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ev_q));
  // R7
  stretch_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stretch_o |=> ($stable(ph_q) && ev_q == '0));
  // R3
  scl_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_q) |-> ev_q[EV_FALL]);
  // R3
  scl_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(scl_q) && $past(en_i)) |-> ev_q[EV_RISE]);
endmodule

// File: rtl/i2c_scl_divider.sv
module i2c_scl_divider
  import i2c_scl_pkg::*;
#(
  parameter int A_W    = 2,
  parameter int B_W    = 6,
  parameter int PHASES = 22
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [A_W-1:0] div_a_i,
  input  logic [B_W-1:0] div_b_i,
  input  logic           scl_i,
  output logic           scl_o,
  output logic [NUM_EV-1:0] ev_o
);
  logic [A_W-1:0] div_a_q;
  logic [B_W-1:0] div_b_q;
  logic           run, a_done, tick, period_end, stretch;

  // capture divisors only when idle or at a period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_a_q <= '0;
      div_b_q <= '0;
    end else if (!en_i || period_end) begin
      div_a_q <= div_a_i;
      div_b_q <= div_b_i;
    end
  end

  assign run = en_i & ~stretch;

  i2c_scl_stage #(.W(A_W)) stage_a_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~en_i),
    .adv_i  (run),
    .lim_i  (div_a_q),
    .done_o (a_done)
  );

  i2c_scl_stage #(.W(B_W)) stage_b_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~en_i),
    .adv_i  (a_done),
    .lim_i  (div_b_q),
    .done_o (tick)
  );

  i2c_scl_phase #(.PHASES(PHASES)) phase_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .tick_i       (tick),
    .scl_i        (scl_i),
    .scl_o        (scl_o),
    .ev_o         (ev_o),
    .period_end_o (period_end),
    .stretch_o    (stretch)
  );

  // R6
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && !$stable({div_a_q, div_b_q})) |-> $past(period_end));
endmodule

// File: tb/i2c_scl_divider_tb.sv
module i2c_scl_divider_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] div_a = '0;
  logic [5:0] div_b = '0;
  logic       hold = 1'b0;
  logic       scl_o;
  logic [3:0] ev;
  logic       scl_line;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;
  assign scl_line = scl_o & ~hold;

  i2c_scl_divider dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .en_i    (en),
    .div_a_i (div_a),
    .div_b_i (div_b),
    .scl_i   (scl_line),
    .scl_o   (scl_o),
    .ev_o    (ev)
  );

  task automatic chk(string req, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ev_map(int p);
    case (p)
      0:  return 4'b0001;
      5:  return 4'b0010;
      11: return 4'b0100;
      16: return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

  // {scl, ev} expected at negedge k after enable; n1 until switch point sw, n2 after
  function automatic logic [4:0] expv(int k, int n1, int n2, int sw);
    int n, t, p;
    if (k < n1) return 5'b10000;
    if (k <= sw) begin n = n1; t = k - n1; end
    else begin n = n2; t = k - sw; end
    p = (t / n) % 22;
    return {p >= 11, (t % n == 0) ? ev_map(p) : 4'b0000};
  endfunction

  task automatic run_case(string req, int a, int b, int a2, int b2, int chg_k, int window);
    int n1, n2, sw, bad_k, bad_act, bad_exp;
    logic [4:0] e;
    n1 = (a + 1) * (b + 1);
    n2 = (a2 + 1) * (b2 + 1);
    sw = 23 * n1;
    if (chg_k == 0) n2 = n1;
    en = 1'b0;
    div_a = 2'(a);
    div_b = 6'(b);
    @(negedge clk);
    @(negedge clk);
    // R1: disabled means released and silent
    chk("R1", scl_o === 1'b1 && ev === 4'b0, {scl_o, ev}, 5'b10000);
    en = 1'b1;
    bad_k = -1; bad_act = 0; bad_exp = 0;
    for (int k = 1; k <= window; k++) begin
      @(negedge clk);
      e = expv(k, n1, n2, sw);
      if (bad_k < 0 && {scl_o, ev} !== e) begin
        bad_k = k; bad_act = {scl_o, ev}; bad_exp = e;
      end
      if (chg_k != 0 && k == chg_k) begin
        div_a = 2'(a2);
        div_b = 6'(b2);
      end
    end
    if (bad_k >= 0) $display("  mismatch at cycle %0d, N=%0d", bad_k, n1);
    chk(req, bad_k < 0, bad_act, bad_exp);
  endtask

  task automatic stretch_case(int a, int b, int h);
    int n, cnt, lim;
    bit quiet;
    n = (a + 1) * (b + 1);
    en = 1'b0;
    div_a = 2'(a);
    div_b = 6'(b);
    @(negedge clk);
    @(negedge clk);
    en = 1'b1;
    lim = 0;
    while (ev !== 4'b0001 && lim < 1000) begin @(negedge clk); lim++; end
    hold = 1'b1;
    lim = 0;
    while (ev !== 4'b0100 && lim < 1000) begin @(negedge clk); lim++; end
    chk("R7", ev === 4'b0100, ev, 4'b0100);
    quiet = 1'b1;
    for (int i = 0; i < h; i++) begin
      @(negedge clk);
      if (ev !== 4'b0 || scl_o !== 1'b1) quiet = 1'b0;
    end
    // R7: frozen while the line is held low
    chk("R7", quiet, ev, 0);
    hold = 1'b0;
    cnt = h;
    lim = 0;
    do begin @(negedge clk); cnt++; lim++; end while (ev === 4'b0 && lim < 2000);
    chk("R7", ev === 4'b1000, ev, 4'b1000);
    chk("R7", cnt == h + 5 * n, cnt, h + 5 * n);
  endtask

  initial begin
    int ra, rb;
    void'($urandom(32'h0000_5eed));
    @(negedge clk);
    // R1: reset state
    chk("R1", scl_o === 1'b1 && ev === 4'b0, {scl_o, ev}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", scl_o === 1'b1 && ev === 4'b0, {scl_o, ev}, 5'b10000);
    // R8 extremes
    run_case("R8", 0, 0, 0, 0, 0, 60);
    run_case("R8", 3, 63, 0, 0, 0, 23 * 256 + 300);
    // R4 strobe placement, R3 duty
    run_case("R4", 1, 2, 0, 0, 0, 150);
    run_case("R3", 2, 0, 0, 0, 0, 100);
    // R6 mid-period divisor change
    run_case("R6", 1, 0, 2, 3, 10, 46 + 12 * 24);
    run_case("R6", 3, 1, 0, 0, 20, 23 * 8 + 40);
    // R2 random divisors
    for (int i = 0; i < 8; i++) begin
      ra = $urandom % 4;
      rb = $urandom % 16;
      run_case("R2", ra, rb, 0, 0, 0, 24 * (ra + 1) * (rb + 1) + 3);
    end
    // R7 stretch
    stretch_case(1, 0, 7);
    stretch_case(0, 2, 13);
    // R5 one strobe at a time is covered by the full-timeline compare above
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1", scl_o === 1'b1 && ev === 4'b0, {scl_o, ev}, 5'b10000);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule